// File: doc/BRIEF.md
# Binary XNOR-Popcount Threshold Neuron

This block computes one binary activation from a binary receptive field. Each input bit is compared with its binary weight: an XNOR gives 1 where the two agree. A balanced adder tree counts the agreeing positions, which gives an unsigned count from 0 to N. A two-bit mode field then picks how the count becomes the activation. The count can be tested against the integer threshold as greater-or-equal or as less-or-equal, or the output can be forced to a constant 0 or 1. This single compare absorbs a folded batch normalisation: the sign of its scale picks the compare direction, and a zero scale picks a constant output.

The neuron has no clock, no registers and no reset. A convolution or fully-connected layer places one copy per output neuron and drives the weights, threshold and mode from stored parameters or ties them to constants. The receptive-field size N is a parameter. The threshold is `$clog2(N+1)` bits wide, so with the two mode bits each neuron needs that many bits plus two, beyond its weights.

Top module: `bnn_neuron`

## Requirements
- R1: The match bit for position k is 1 exactly when rf_i[k] equals weight_i[k]. The count is the number of match bits, an unsigned value from 0 to N.
- R2: With mode_i = 2'b00, act_o is 1 exactly when the count is greater than or equal to thresh_i.
- R3: With mode_i = 2'b01, act_o is 1 exactly when the count is less than or equal to thresh_i.
- R4: With mode_i = 2'b10, act_o is 0 whatever rf_i, weight_i and thresh_i are.
- R5: With mode_i = 2'b11, act_o is 1 whatever rf_i, weight_i and thresh_i are.
- R6: act_o is a pure combinational function of the present inputs and settles in the time step in which they change, with no clock edge.
- R7: thresh_i uses its full unsigned range. A threshold above N gives act_o = 0 in mode 2'b00 and act_o = 1 in mode 2'b01. A threshold of 0 gives act_o = 1 in mode 2'b00.
- R8: Every bit position counts with the same weight. With rf_i equal to weight_i except at one position and thresh_i = N, mode 2'b00 gives act_o = 0 whichever position differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_i | input | N | Binary receptive-field bits |
| weight_i | input | N | Binary weight bits, one per receptive-field bit |
| thresh_i | input | $clog2(N+1) | Unsigned integer threshold |
| mode_i | input | 2 | 00 ge-compare, 01 le-compare, 10 constant 0, 11 constant 1 |
| act_o | output | 1 | Binary output activation |

## Verification
The checker treats the neuron as combinational. It assumes that every input holds a known 0 or 1 and that all inputs of one test vector change together in a single time step. Its checks therefore fire only after the output has settled, and they mostly test properties that follow from the port values alone: the constant modes, the threshold extremes, and full agreement or full disagreement between rf_i and weight_i. The bench changes all inputs at once at a clock edge and samples half a period later. It draws thresholds over the whole 4-bit range, including values above N, and covers all four mode codes, so every input it applies stays within what the checker assumes.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
  typedef enum logic [1:0] {
    MODE_GE   = 2'b00,
    MODE_LE   = 2'b01,
    MODE_ZERO = 2'b10,
    MODE_ONE  = 2'b11
  } act_mode_e;
endpackage

// File: rtl/bnn_xnor_stage.sv
module bnn_xnor_stage #(
  parameter int N = 9
) (
  input  logic [N-1:0] rf_i,
  input  logic [N-1:0] weight_i,
  output logic [N-1:0] match_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    assign match_o[k] = ~(rf_i[k] ^ weight_i[k]);
  end
endmodule

// File: rtl/bnn_popcount.sv
module bnn_popcount #(
  parameter int N    = 9,
  parameter int CNTW = $clog2(N) + 1
) (
  input  logic [N-1:0]    bits_i,
  output logic [CNTW-1:0] cnt_o
);
  localparam int LEVELS = $clog2(N);
  localparam int P      = 1 << LEVELS;

  // heap-indexed tree: leaves at P..2P-1, root at 1
  logic [CNTW-1:0] node [1:2*P-1];

  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < N) begin : g_real
      assign node[P+k] = CNTW'(bits_i[k]);
    end else begin : g_pad
      assign node[P+k] = '0;
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_add
    assign node[i] = node[2*i] + node[2*i+1];
  end

  assign cnt_o = node[1];
endmodule

// File: rtl/bnn_decide.sv
module bnn_decide
  import bnn_pkg::*;
#(
  parameter int CNTW = 5,
  parameter int TW   = 4
) (
  input  logic [CNTW-1:0] cnt_i,
  input  logic [TW-1:0]   thresh_i,
  input  act_mode_e       mode_i,
  output logic            act_o
);
  localparam int CMPW = (CNTW > TW) ? CNTW : TW;

  logic [CMPW-1:0] cnt_x, thr_x;
  assign cnt_x = CMPW'(cnt_i);
  assign thr_x = CMPW'(thresh_i);

  always_comb begin
    unique case (mode_i)
      MODE_GE:   act_o = (cnt_x >= thr_x);
      MODE_LE:   act_o = (cnt_x <= thr_x);
      MODE_ZERO: act_o = 1'b0;
      MODE_ONE:  act_o = 1'b1;
      default:   act_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnn_neuron.sv
module bnn_neuron
  import bnn_pkg::*;
#(
  parameter int N  = 9,
  parameter int TW = $clog2(N + 1)
) (
  input  logic [N-1:0]  rf_i,
  input  logic [N-1:0]  weight_i,
  input  logic [TW-1:0] thresh_i,
  input  logic [1:0]    mode_i,
  output logic          act_o
);
  localparam int CNTW = $clog2(N) + 1;

  logic [N-1:0]    match;
  logic [CNTW-1:0] cnt;

  bnn_xnor_stage #(.N(N)) i_xnor (
    .rf_i     (rf_i),
    .weight_i (weight_i),
    .match_o  (match)
  );

  bnn_popcount #(.N(N), .CNTW(CNTW)) i_popcount (
    .bits_i (match),
    .cnt_o  (cnt)
  );

  bnn_decide #(.CNTW(CNTW), .TW(TW)) i_decide (
    .cnt_i    (cnt),
    .thresh_i (thresh_i),
    .mode_i   (act_mode_e'(mode_i)),
    .act_o    (act_o)
  );
endmodule

// File: rtl/bnn_neuron_chk.sv
module bnn_neuron_chk #(
  parameter int N  = 9,
  parameter int TW = $clog2(N + 1)
) (
  input logic [N-1:0]  rf_i,
  input logic [N-1:0]  weight_i,
  input logic [TW-1:0] thresh_i,
  input logic [1:0]    mode_i,
  input logic          act_o
);
  localparam int TWX = TW + 1;

  always_comb begin
    assert_const_zero_R4: assert (!(mode_i == 2'b10) || act_o == 1'b0);
    assert_const_one_R5:  assert (!(mode_i == 2'b11) || act_o == 1'b1);
    assert_ge_zero_thr_R7: assert (!(mode_i == 2'b00 && thresh_i == '0) || act_o);
    assert_ge_high_thr_R7: assert (!(mode_i == 2'b00 && TWX'(thresh_i) > TWX'(N)) || !act_o);
    assert_le_high_thr_R3: assert (!(mode_i == 2'b01 && TWX'(thresh_i) >= TWX'(N)) || act_o);
    assert_full_match_R2:  assert (!(mode_i == 2'b00 && rf_i == weight_i && TWX'(thresh_i) <= TWX'(N)) || act_o);
    assert_no_match_R1:    assert (!(mode_i == 2'b01 && rf_i == ~weight_i) || act_o);
  end
endmodule

bind bnn_neuron bnn_neuron_chk #(.N(N), .TW(TW)) i_bnn_neuron_chk (
  .rf_i     (rf_i),
  .weight_i (weight_i),
  .thresh_i (thresh_i),
  .mode_i   (mode_i),
  .act_o    (act_o)
);

// File: tb/test_bnn_neuron.sv
module test_bnn_neuron;
  localparam int N  = 9;
  localparam int TW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]  rf, wt;
  logic [TW-1:0] thr;
  logic [1:0]    mode;
  logic          act;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bnn_neuron #(.N(N)) i_bnn_neuron (
    .rf_i     (rf),
    .weight_i (wt),
    .thresh_i (thr),
    .mode_i   (mode),
    .act_o    (act)
  );

  function automatic int count_agree(logic [N-1:0] a, logic [N-1:0] b);
    int c = 0;
    for (int k = 0; k < N; k++) if (a[k] == b[k]) c++;
    return c;
  endfunction

  function automatic logic model(logic [N-1:0] a, logic [N-1:0] b,
                                 logic [TW-1:0] t, logic [1:0] m);
    int c = count_agree(a, b);
    case (m)
      2'b00:   return (c >= int'(t));
      2'b01:   return (c <= int'(t));
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // drive at posedge, sample at the following negedge
  task automatic apply_check(logic [N-1:0] a, logic [N-1:0] b,
                             logic [TW-1:0] t, logic [1:0] m, string req);
    logic e;
    @(posedge clk);
    rf = a; wt = b; thr = t; mode = m;
    @(negedge clk);
    e = model(a, b, t, m);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s rf=%h w=%h thr=%0d mode=%b act=%b exp=%b",
               req, a, b, t, m, act, e);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rf = '0; wt = '0; thr = '0; mode = 2'b10;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // initial state: constant-0 mode
    apply_check('0, '0, '0, 2'b10, "R4");
    // full agreement, threshold N
    apply_check(9'h1a5, 9'h1a5, TW'(N), 2'b00, "R2");
    apply_check(9'h0f0, ~9'h0f0, '0, 2'b01, "R1");
    apply_check(9'h0f0, ~9'h0f0, 4'd1, 2'b00, "R1");
    // R8: single disagreement at each position
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] b = 9'h133;
      apply_check(b ^ (N'(1) << k), b, TW'(N), 2'b00, "R8");
      apply_check(b ^ (N'(1) << k), b, TW'(N - 1), 2'b00, "R8");
    end
    // R7: threshold sweep above N and at 0
    for (int t = 0; t < (1 << TW); t++) begin
      apply_check(9'h1ff, 9'h1ff, TW'(t), 2'b00, "R7");
      apply_check(9'h000, 9'h1ff, TW'(t), 2'b01, "R7");
      apply_check(9'h0aa, 9'h0cc, TW'(t), 2'b00, "R2");
      apply_check(9'h0aa, 9'h0cc, TW'(t), 2'b01, "R3");
    end
    // R4/R5: constants ignore data
    for (int i = 0; i < 50; i++) begin
      apply_check(N'($urandom), N'($urandom), TW'($urandom), 2'b10, "R4");
      apply_check(N'($urandom), N'($urandom), TW'($urandom), 2'b11, "R5");
    end
    // R6: back-to-back changes settle without waiting for extra edges
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] m = 2'($urandom);
      apply_check(N'($urandom), N'($urandom), TW'($urandom_range(0, (1 << TW) - 1)), m,
                  m == 2'b00 ? "R2" : m == 2'b01 ? "R3" : m == 2'b10 ? "R4" : "R5");
    end
    for (int i = 0; i < 200; i++) begin
      logic [N-1:0] a = N'($urandom);
      logic [TW-1:0] t = TW'($urandom);
      apply_check(a, a, t, 2'b00, "R6");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 act=%b exp=completion", act);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule